// File: doc/BRIEF.md
# Asymmetric Four-Pipe Instruction Slotter

This block sits between instruction decode and the execution pipes. Each clock it receives a group of up to four decoded instructions. Each instruction carries a valid bit and a three-bit operation class. The block assigns each instruction, in program order, to one of four execution pipes: integer pipe 0, integer pipe 1, floating-point add pipe and floating-point multiply pipe. The pipes do not all accept the same work, so the block has to match each operation class against the pipes that can execute it.

Slotting stops at the first valid instruction that has no free, capable pipe. Later instructions in the group are held back even when a pipe would be free for them. The block reports a per-slot issue flag and pipe number, the number of slots consumed, and how many valid instructions are left over. The upstream stage uses these counts to stall and present the leftovers again. All results are registered and appear one clock after the group is presented.

Top module: `slot_top`

## Requirements
- R1: Results for a group presented at a rising clock edge appear on the outputs after that edge and stay there until the next edge. There is exactly one register stage.
- R2: Operation class codes are 0 simple integer ALU, 1 integer multiply/shift, 2 branch/jump, 3 load, 4 store, 5 floating-point non-multiply, 6 floating-point multiply and 7 unplaceable. Pipe codes on `pipeOut` are 0 integer pipe 0, 1 integer pipe 1, 2 FP add pipe and 3 FP multiply pipe. Slot k uses `instClass[3k+2:3k]` and `pipeOut[2k+1:2k]`.
- R3: An ALU or load instruction goes to integer pipe 0 if that pipe is still free this cycle, otherwise to integer pipe 1. If both integer pipes are taken, the instruction blocks.
- R4: Multiply/shift and store instructions go only to integer pipe 0. They block if that pipe is taken.
- R5: Branch instructions go only to integer pipe 1. They block if that pipe is taken.
- R6: Floating-point non-multiply instructions go only to pipe 2. Floating-point multiplies go only to pipe 3.
- R7: Each pipe receives at most one instruction per cycle.
- R8: Once a valid instruction blocks, no later slot in the group is issued.
- R9: A slot whose valid bit is clear is never issued and never blocks. Its `pipeOut` field reads 0.
- R10: `consumedOut` equals the index of the first blocking slot, or 4 if nothing blocks. `leftoverOut` equals the number of valid slots at or after that index.
- R11: Class 7 never issues and always blocks when valid.
- R12: While reset is high, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 4 | Per-slot valid bits, slot 0 oldest |
| instClass | input | 12 | Per-slot operation class, 3 bits each |
| issueOut | output | 4 | Per-slot issue flag |
| pipeOut | output | 8 | Per-slot pipe number, 2 bits each |
| consumedOut | output | 3 | Slots consumed this cycle |
| leftoverOut | output | 3 | Valid instructions left for the next cycle |

## Verification
The checker watches every cycle for the following properties:
- no pipe takes two instructions;
- restricted classes land only on their allowed pipes;
- no issued slot lies at or past the consumed index;
- invalid slots never issue;
- consumed plus leftover never exceeds the group size.

Some behaviours can only be shown by the bench's scenarios, where the scoreboard compares exact assignments:
- the pipe-0-first preference for flexible classes;
- in-order blocking that leaves a free pipe unused;
- the exact leftover count.

// File: rtl/slot_pkg.sv
package slot_pkg;
  localparam int SLOT_CNT = 4;
  localparam int PIPE_CNT = 4;
  localparam int CLASS_W  = 3;
  localparam int PIPE_W   = $clog2(PIPE_CNT);
  localparam int CNT_W    = $clog2(SLOT_CNT + 1);

  typedef enum logic [CLASS_W-1:0] {
    OP_ALU    = 3'd0,
    OP_MULSHF = 3'd1,
    OP_BRANCH = 3'd2,
    OP_LOAD   = 3'd3,
    OP_STORE  = 3'd4,
    OP_FPOP   = 3'd5,
    OP_FPMUL  = 3'd6,
    OP_NONE   = 3'd7
  } opClass_t;

  localparam logic [PIPE_W-1:0] PIPE_INT0 = 2'd0;
  localparam logic [PIPE_W-1:0] PIPE_INT1 = 2'd1;
  localparam logic [PIPE_W-1:0] PIPE_FPA  = 2'd2;
  localparam logic [PIPE_W-1:0] PIPE_FPM  = 2'd3;

  typedef struct packed {
    logic [SLOT_CNT-1:0]             issue;
    logic [SLOT_CNT-1:0][PIPE_W-1:0] pipe;
    logic [CNT_W-1:0]                stopIdx;
  } slotStrobe_t;
endpackage

// File: rtl/slot_ctrl.sv
module slot_ctrl
  import slot_pkg::*;
(
  input  logic [SLOT_CNT-1:0]         instValid,
  input  logic [SLOT_CNT*CLASS_W-1:0] instClass,
  output slotStrobe_t                 strobe
);
  logic [PIPE_CNT-1:0] busy;
  logic                stopped;
  logic                placed;
  logic [PIPE_W-1:0]   pick;
  opClass_t            cls;

  always_comb begin
    busy           = '0;
    stopped        = 1'b0;
    placed         = 1'b0;
    pick           = PIPE_INT0;
    cls            = OP_ALU;
    strobe.issue   = '0;
    strobe.pipe    = '0;
    strobe.stopIdx = CNT_W'(SLOT_CNT);
    for (int k = 0; k < SLOT_CNT; k++) begin
      cls    = opClass_t'(instClass[k*CLASS_W +: CLASS_W]);
      placed = 1'b0;
      pick   = PIPE_INT0;
      case (cls)
        OP_ALU, OP_LOAD: begin
          if (!busy[PIPE_INT0]) begin
            placed = 1'b1;
            pick   = PIPE_INT0;
          end else if (!busy[PIPE_INT1]) begin
            placed = 1'b1;
            pick   = PIPE_INT1;
          end
        end
        OP_MULSHF, OP_STORE: begin
          placed = !busy[PIPE_INT0];
          pick   = PIPE_INT0;
        end
        OP_BRANCH: begin
          placed = !busy[PIPE_INT1];
          pick   = PIPE_INT1;
        end
        OP_FPOP: begin
          placed = !busy[PIPE_FPA];
          pick   = PIPE_FPA;
        end
        OP_FPMUL: begin
          placed = !busy[PIPE_FPM];
          pick   = PIPE_FPM;
        end
        default: placed = 1'b0;
      endcase
      if (!stopped && instValid[k]) begin
        if (placed) begin
          busy[pick]      = 1'b1;
          strobe.issue[k] = 1'b1;
          strobe.pipe[k]  = pick;
        end else begin
          stopped        = 1'b1;
          strobe.stopIdx = CNT_W'(k);
        end
      end
    end
  end
endmodule

// File: rtl/slot_dpath.sv
module slot_dpath
  import slot_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic [SLOT_CNT-1:0]        instValid,
  input  slotStrobe_t                strobe,
  output logic [SLOT_CNT-1:0]        issueOut,
  output logic [SLOT_CNT*PIPE_W-1:0] pipeOut,
  output logic [CNT_W-1:0]           consumedOut,
  output logic [CNT_W-1:0]           leftoverOut
);
  logic [CNT_W-1:0] leftCount;

  always_comb begin
    leftCount = '0;
    for (int k = 0; k < SLOT_CNT; k++) begin
      if (instValid[k] && (CNT_W'(k) >= strobe.stopIdx))
        leftCount = leftCount + 1'b1;
    end
  end

  for (genvar g = 0; g < SLOT_CNT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        issueOut[g]                    <= 1'b0;
        pipeOut[g*PIPE_W +: PIPE_W]    <= '0;
      end else begin
        issueOut[g]                    <= strobe.issue[g];
        pipeOut[g*PIPE_W +: PIPE_W]    <= strobe.pipe[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      consumedOut <= '0;
      leftoverOut <= '0;
    end else begin
      consumedOut <= strobe.stopIdx;
      leftoverOut <= leftCount;
    end
  end
endmodule

// File: rtl/slot_top.sv
module slot_top
  import slot_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  instValid,
  input  logic [11:0] instClass,
  output logic [3:0]  issueOut,
  output logic [7:0]  pipeOut,
  output logic [2:0]  consumedOut,
  output logic [2:0]  leftoverOut
);
  slotStrobe_t strobe;

  slot_ctrl u_ctrl (
    .instValid (instValid),
    .instClass (instClass),
    .strobe    (strobe)
  );

  slot_dpath u_dpath (
    .clk         (clk),
    .rst         (rst),
    .instValid   (instValid),
    .strobe      (strobe),
    .issueOut    (issueOut),
    .pipeOut     (pipeOut),
    .consumedOut (consumedOut),
    .leftoverOut (leftoverOut)
  );
endmodule

// File: rtl/slot_chk.sv
module slot_chk
  import slot_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [3:0]  instValid,
  input logic [11:0] instClass,
  input logic [3:0]  issueOut,
  input logic [7:0]  pipeOut,
  input logic [2:0]  consumedOut,
  input logic [2:0]  leftoverOut
);
  logic [PIPE_CNT-1:0][SLOT_CNT-1:0] pipeHits;

  always_comb begin
    pipeHits = '0;
    for (int k = 0; k < SLOT_CNT; k++)
      if (issueOut[k]) pipeHits[pipeOut[k*PIPE_W +: PIPE_W]][k] = 1'b1;
  end

  for (genvar p = 0; p < PIPE_CNT; p++) begin : g_pipe
    // R7
    one_per_pipe_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(pipeHits[p]) <= 1);
  end

  for (genvar k = 0; k < SLOT_CNT; k++) begin : g_slot
    // R9
    invalid_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
      issueOut[k] |-> $past(instValid[k]));
    // R8
    issue_before_stop_chk: assert property (@(posedge clk) disable iff (rst)
      issueOut[k] |-> (3'(k) < consumedOut));
    // R4
    int0_only_chk: assert property (@(posedge clk) disable iff (rst)
      (issueOut[k] && ($past(instClass[k*3 +: 3]) == 3'd1 || $past(instClass[k*3 +: 3]) == 3'd4))
      |-> pipeOut[k*2 +: 2] == 2'd0);
    // R5
    branch_int1_chk: assert property (@(posedge clk) disable iff (rst)
      (issueOut[k] && $past(instClass[k*3 +: 3]) == 3'd2) |-> pipeOut[k*2 +: 2] == 2'd1);
    // R6
    fp_pipe_chk: assert property (@(posedge clk) disable iff (rst)
      (issueOut[k] && $past(instClass[k*3 +: 3]) == 3'd5) |-> pipeOut[k*2 +: 2] == 2'd2);
    // R11
    none_class_chk: assert property (@(posedge clk) disable iff (rst)
      issueOut[k] |-> $past(instClass[k*3 +: 3]) != 3'd7);
  end

  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(consumedOut) + 32'(leftoverOut)) <= SLOT_CNT);
endmodule

bind slot_top slot_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .instValid   (instValid),
  .instClass   (instClass),
  .issueOut    (issueOut),
  .pipeOut     (pipeOut),
  .consumedOut (consumedOut),
  .leftoverOut (leftoverOut)
);

// File: tb/slot_top_tb.sv
module slot_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  instValid = '0;
  logic [11:0] instClass = '0;
  logic [3:0]  issueOut;
  logic [7:0]  pipeOut;
  logic [2:0]  consumedOut;
  logic [2:0]  leftoverOut;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0] issue;
    logic [7:0] pipe;
    logic [2:0] consumed;
    logic [2:0] leftover;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];

  always #2 clk = ~clk;

  slot_top u_dut (
    .clk(clk), .rst(rst), .instValid(instValid), .instClass(instClass),
    .issueOut(issueOut), .pipeOut(pipeOut),
    .consumedOut(consumedOut), .leftoverOut(leftoverOut)
  );

  function automatic expItem_t predict(input logic [3:0] v, input logic [11:0] c, input string tag);
    expItem_t e;
    bit [3:0] used = '0;
    bit blocked = 1'b0;
    e.issue = '0; e.pipe = '0; e.consumed = 3'd4; e.leftover = '0; e.tag = tag;
    for (int k = 0; k < 4; k++) begin
      int dest;
      dest = -1;
      if (v[k] && !blocked) begin
        case (c[k*3 +: 3])
          3'd0, 3'd3: dest = !used[0] ? 0 : (!used[1] ? 1 : -1);
          3'd1, 3'd4: dest = !used[0] ? 0 : -1;
          3'd2:       dest = !used[1] ? 1 : -1;
          3'd5:       dest = !used[2] ? 2 : -1;
          3'd6:       dest = !used[3] ? 3 : -1;
          default:    dest = -1;
        endcase
        if (dest < 0) begin
          blocked = 1'b1;
          e.consumed = 3'(k);
        end else begin
          used[dest] = 1'b1;
          e.issue[k] = 1'b1;
          e.pipe[k*2 +: 2] = 2'(dest);
        end
      end
      if (blocked && v[k]) e.leftover = e.leftover + 1'b1;
    end
    return e;
  endfunction

  task automatic drive(input logic [3:0] v, input logic [11:0] c, input string tag);
    @(negedge clk);
    instValid = v;
    instClass = c;
    expQ.push_back(predict(v, c, tag));
  endtask

  function automatic logic [11:0] pack4(input int a, input int b, input int c, input int d);
    return {3'(d), 3'(c), 3'(b), 3'(a)};
  endfunction

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (!rst && expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        compared++;
        if (issueOut !== e.issue || pipeOut !== e.pipe ||
            consumedOut !== e.consumed || leftoverOut !== e.leftover) begin
          mismatched++;
          $display("FAIL %s: got issue=%b pipe=%h consumed=%0d left=%0d, expected issue=%b pipe=%h consumed=%0d left=%0d",
                   e.tag, issueOut, pipeOut, consumedOut, leftoverOut,
                   e.issue, e.pipe, e.consumed, e.leftover);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got run still active, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stim
    instValid = 4'hF;
    instClass = pack4(5, 6, 2, 1);
    repeat (3) @(posedge clk);
    #1;
    compared++;
    if (issueOut !== 0 || pipeOut !== 0 || consumedOut !== 0 || leftoverOut !== 0) begin
      mismatched++;
      $display("FAIL R12: got issue=%b pipe=%h consumed=%0d left=%0d, expected all zero",
               issueOut, pipeOut, consumedOut, leftoverOut);
    end
    @(negedge clk);
    rst = 1'b0;
    instValid = '0;
    // R1 R2 R6: every pipe used once in a mixed group
    drive(4'hF, pack4(5, 6, 0, 2), "R1 R2 R6 mixed");
    // R3: third ALU finds both integer pipes taken
    drive(4'hF, pack4(0, 0, 0, 5), "R3 alu overflow");
    // R3: load after multiply falls to integer pipe 1
    drive(4'hF, pack4(1, 3, 6, 5), "R3 load to int1");
    // R4: second store blocks
    drive(4'hF, pack4(4, 4, 5, 6), "R4 store conflict");
    // R4: multiply behind ALU blocks because pipe 0 is taken
    drive(4'hF, pack4(0, 1, 5, 6), "R4 mulshf blocked");
    // R5: two branches
    drive(4'hF, pack4(2, 2, 0, 0), "R5 branch conflict");
    // R6: two FP multiplies
    drive(4'hF, pack4(6, 6, 5, 0), "R6 fpmul conflict");
    // R8: blocked slot hides free FP pipe
    drive(4'hF, pack4(0, 0, 0, 5), "R8 in order stop");
    // R9: gaps do not block
    drive(4'b1010, pack4(4, 4, 7, 2), "R9 invalid gaps");
    drive(4'b0000, pack4(7, 7, 7, 7), "R9 R10 empty group");
    // R11: unplaceable class at slot 0
    drive(4'hF, pack4(7, 0, 5, 6), "R11 class7 head");
    // R11: invalid class-7 slot is skipped
    drive(4'b1101, pack4(0, 7, 5, 6), "R9 R11 invalid class7");
    // R10: leftover counts only valid slots after the stop
    drive(4'b1011, pack4(1, 1, 0, 2), "R10 leftover");
    for (int i = 0; i < 300; i++)
      drive(4'($urandom), 12'($urandom), "R7 R10 random");
    @(negedge clk);
    instValid = '0;
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule